// File: doc/BRIEF.md
# Clock Divider Shadow-Update Controller

This block holds the divider settings for a clock generator: an input prescaler, a feedback multiplier, two cascaded output postscalers and a separate integer divider for the oscillator tap. Software writes new settings into staging registers over a simple register interface. The staged settings have no effect until software raises a request bit for their group. Three groups exist. The first holds the prescaler and feedback value. The second holds both postscalers. The third holds the oscillator-tap divider. The clock path then computes its output as input × feedback ÷ (prescaler × postscaler one × postscaler two). The tap output is the oscillator frequency ÷ (2 × tap divider).

Each request crosses into the target clock domain through a four-phase handshake. Every group has its own bus-side state machine with the states IDLE, REQ and DRAIN. A write of 1 to the group's request bit moves IDLE to REQ. When the synchronized acknowledge goes high, REQ moves to DRAIN. When the acknowledge falls again, DRAIN moves back to IDLE. Each group also has a target-side machine with the states WAIT and ACKED. In WAIT, a synchronized request loads the active registers and moves the machine to ACKED. A dropped request moves ACKED back to WAIT. The request bit reads 1 for as long as the bus-side machine is away from IDLE, and software polls it until it clears.

Top module: `clkdiv_shadow_ctrl`

## Requirements
- R1: After reset, every staging and every active value equals 1 and the control register reads 0.
- R2: Staging registers are read back at addresses 1 (prescaler), 2 (feedback), 3 (postscaler one), 4 (postscaler two) and 5 (tap divider), right-aligned in `rdata`. Address 0 is the control register, whose bits 0, 1 and 2 are the request bits of the three groups.
- R3: Writing 1 to control bit 0 copies the staged prescaler and feedback values into `act_pre` and `act_fb` in the same target clock cycle. No other active output changes.
- R4: Writing 1 to control bit 1 copies both staged postscalers into `act_post1` and `act_post2` together. No other active output changes.
- R5: Writing 1 to control bit 2 copies the staged tap divider into `act_vco`. No other active output changes.
- R6: A request bit reads 1 from the cycle after it is written. Hardware clears it only after the acknowledge has returned. The active registers already hold the new values when it reads 0.
- R7: A write to a staging register is ignored while its group's request bit is set.
- R8: A staged value of 0 is applied as 1 to the active register, while the staging register still reads back 0.
- R9: Staging writes alone never change an active output.
- R10: Writing 0 to a control bit has no effect. Several request bits may be set in one write, and they complete independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock |
| tclk | input | 1 | Target clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address for both reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| act_pre | output | PRE_W | Active prescaler (tclk domain) |
| act_fb | output | FB_W | Active feedback value (tclk domain) |
| act_post1 | output | POST_W | Active postscaler one (tclk domain) |
| act_post2 | output | POST_W | Active postscaler two (tclk domain) |
| act_vco | output | VCO_W | Active tap divider (tclk domain) |

## Verification
The transfer function is tried in several ways. Each group is triggered alone, which shows whether a request moves only its own fields. All three bits are then set in one write, which shows whether the groups stay independent when their handshakes overlap. Staged zeros are applied, which separates the zero-to-one substitution from a plain copy. Staging is written during a pending request, which shows whether the values in flight are locked. All fields are set to their widest values, which exposes truncated paths. A scoreboard records the expected active values at each completed poll and checks them against the outputs, so a late load or a wrong grouping shows up as a mismatch.

// File: rtl/clkdiv_shadow_pkg.sv
package clkdiv_shadow_pkg;
    localparam int unsigned GROUPS = 3;
    localparam int unsigned G_REF  = 0;
    localparam int unsigned G_POST = 1;
    localparam int unsigned G_VCO  = 2;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_PRE   = 3'd1,
        A_FB    = 3'd2,
        A_POST1 = 3'd3,
        A_POST2 = 3'd4,
        A_VCO   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_DRAIN
    } src_state_e;

    typedef enum logic {
        D_WAIT,
        D_ACKED
    } dst_state_e;
endpackage

// File: rtl/cds_req_src.sv
module cds_req_src
    import clkdiv_shadow_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_async,
    output logic req,
    output logic busy
);
    logic [SYNC_STAGES-1:0] ack_sync;
    logic                   ack_s;
    src_state_e             state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_sync <= '0;
        else        ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_async};
    end
    assign ack_s = ack_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start)  state_nx = S_REQ;
            S_REQ:   if (ack_s)  state_nx = S_DRAIN;
            S_DRAIN: if (!ack_s) state_nx = S_IDLE;
            default:             state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        req  = (state == S_REQ);
        busy = (state != S_IDLE);
    end
endmodule

// File: rtl/cds_req_dst.sv
module cds_req_dst
    import clkdiv_shadow_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic tclk,
    input  logic rst_n,
    input  logic req_async,
    output logic ack,
    output logic load
);
    logic [SYNC_STAGES-1:0] req_sync;
    logic                   req_s;
    dst_state_e             state, state_nx;

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= {req_sync[SYNC_STAGES-2:0], req_async};
    end
    assign req_s = req_sync[SYNC_STAGES-1];

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) state <= D_WAIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            D_WAIT:  if (req_s)  state_nx = D_ACKED;
            D_ACKED: if (!req_s) state_nx = D_WAIT;
            default:             state_nx = D_WAIT;
        endcase
    end

    always_comb begin
        ack  = (state == D_ACKED);
        load = (state == D_WAIT) && req_s;
    end
endmodule

// File: rtl/clkdiv_shadow_ctrl.sv
module clkdiv_shadow_ctrl
    import clkdiv_shadow_pkg::*;
#(
    parameter int unsigned DW          = 16,
    parameter int unsigned PRE_W       = 5,
    parameter int unsigned FB_W        = 9,
    parameter int unsigned POST_W      = 3,
    parameter int unsigned VCO_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              tclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [PRE_W-1:0]  act_pre,
    output logic [FB_W-1:0]   act_fb,
    output logic [POST_W-1:0] act_post1,
    output logic [POST_W-1:0] act_post2,
    output logic [VCO_W-1:0]  act_vco
);
    reg_addr_e          sel;
    logic [GROUPS-1:0]  start, req, ack, load, busy;
    logic [PRE_W-1:0]   stg_pre;
    logic [FB_W-1:0]    stg_fb;
    logic [POST_W-1:0]  stg_post1, stg_post2;
    logic [VCO_W-1:0]   stg_vco;
    logic [PRE_W-1:0]   app_pre;
    logic [FB_W-1:0]    app_fb;
    logic [POST_W-1:0]  app_post1, app_post2;
    logic [VCO_W-1:0]   app_vco;

    assign sel = reg_addr_e'(addr);

    // staging registers, locked while their group is in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_pre   <= PRE_W'(1);
            stg_fb    <= FB_W'(1);
            stg_post1 <= POST_W'(1);
            stg_post2 <= POST_W'(1);
            stg_vco   <= VCO_W'(1);
        end else if (wr_en) begin
            if (sel == A_PRE   && !busy[G_REF])  stg_pre   <= wdata[PRE_W-1:0];
            if (sel == A_FB    && !busy[G_REF])  stg_fb    <= wdata[FB_W-1:0];
            if (sel == A_POST1 && !busy[G_POST]) stg_post1 <= wdata[POST_W-1:0];
            if (sel == A_POST2 && !busy[G_POST]) stg_post2 <= wdata[POST_W-1:0];
            if (sel == A_VCO   && !busy[G_VCO])  stg_vco   <= wdata[VCO_W-1:0];
        end
    end

    // per-group request/acknowledge handshakes
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign start[g] = wr_en && (sel == A_CTRL) && wdata[g];

        cds_req_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[g]),
            .ack_async (ack[g]),
            .req       (req[g]),
            .busy      (busy[g])
        );

        cds_req_dst #(.SYNC_STAGES(SYNC_STAGES)) u_dst (
            .tclk      (tclk),
            .rst_n     (rst_n),
            .req_async (req[g]),
            .ack       (ack[g]),
            .load      (load[g])
        );
    end

    // zero staged divisors become one on the way to the clock path
    assign app_pre   = (stg_pre   == '0) ? PRE_W'(1)  : stg_pre;
    assign app_fb    = (stg_fb    == '0) ? FB_W'(1)   : stg_fb;
    assign app_post1 = (stg_post1 == '0) ? POST_W'(1) : stg_post1;
    assign app_post2 = (stg_post2 == '0) ? POST_W'(1) : stg_post2;
    assign app_vco   = (stg_vco   == '0) ? VCO_W'(1)  : stg_vco;

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            act_pre   <= PRE_W'(1);
            act_fb    <= FB_W'(1);
            act_post1 <= POST_W'(1);
            act_post2 <= POST_W'(1);
            act_vco   <= VCO_W'(1);
        end else begin
            if (load[G_REF]) begin
                act_pre <= app_pre;
                act_fb  <= app_fb;
            end
            if (load[G_POST]) begin
                act_post1 <= app_post1;
                act_post2 <= app_post2;
            end
            if (load[G_VCO]) act_vco <= app_vco;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            A_CTRL:  rdata = DW'(busy);
            A_PRE:   rdata = DW'(stg_pre);
            A_FB:    rdata = DW'(stg_fb);
            A_POST1: rdata = DW'(stg_post1);
            A_POST2: rdata = DW'(stg_post2);
            A_VCO:   rdata = DW'(stg_vco);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkdiv_shadow_chk.sv
module clkdiv_shadow_chk #(
    parameter int unsigned PRE_W  = 5,
    parameter int unsigned FB_W   = 9,
    parameter int unsigned POST_W = 3,
    parameter int unsigned VCO_W  = 8
) (
    input logic              clk,
    input logic              tclk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [15:0]       wdata,
    input logic [2:0]        busy,
    input logic [2:0]        load,
    input logic [PRE_W-1:0]  stg_pre,
    input logic [FB_W-1:0]   stg_fb,
    input logic [POST_W-1:0] stg_post1,
    input logic [VCO_W-1:0]  stg_vco,
    input logic [PRE_W-1:0]  act_pre,
    input logic [FB_W-1:0]   act_fb,
    input logic [POST_W-1:0] act_post1,
    input logic [POST_W-1:0] act_post2,
    input logic [VCO_W-1:0]  act_vco
);
    AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata[0]) |=> busy[0]); // R6

    AST_STG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy[0] |=> $stable(stg_pre) || !$past(busy[0])); // R7

    AST_PRE_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[0]) |-> act_pre == ((stg_pre == '0) ? PRE_W'(1) : stg_pre)); // R3

    AST_POST_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[1]) |-> act_post1 == ((stg_post1 == '0) ? POST_W'(1) : stg_post1)); // R4

    AST_VCO_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy[2]) |-> act_vco == ((stg_vco == '0) ? VCO_W'(1) : stg_vco)); // R5

    AST_NO_ZERO_DIV: assert property (@(posedge tclk) disable iff (!rst_n)
        act_pre != '0 && act_fb != '0 && act_post1 != '0 && act_post2 != '0 && act_vco != '0); // R8

    AST_FB_HOLDS: assert property (@(posedge tclk) disable iff (!rst_n)
        !load[0] |=> $stable(act_fb)); // R9

    AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(stg_fb) |-> !busy[0] || !$past(busy[0])); // R7
endmodule

bind clkdiv_shadow_ctrl clkdiv_shadow_chk #(
    .PRE_W(PRE_W), .FB_W(FB_W), .POST_W(POST_W), .VCO_W(VCO_W)
) u_chk (
    .clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .busy(busy), .load(load), .stg_pre(stg_pre),
    .stg_fb(stg_fb), .stg_post1(stg_post1), .stg_vco(stg_vco),
    .act_pre(act_pre), .act_fb(act_fb), .act_post1(act_post1),
    .act_post2(act_post2), .act_vco(act_vco)
);

// File: tb/test_clkdiv_shadow_ctrl.sv
module test_clkdiv_shadow_ctrl;
    logic        clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [4:0]  act_pre;
    logic [8:0]  act_fb;
    logic [2:0]  act_post1, act_post2;
    logic [7:0]  act_vco;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        string tag;
        int    pre, fb, p1, p2, vco;
    } exp_t;
    exp_t sb_q[$];

    // bench model of the active registers
    int m_pre = 1, m_fb = 1, m_p1 = 1, m_p2 = 1, m_vco = 1;

    always #10 clk  = ~clk;
    always #7  tclk = ~tclk;

    clkdiv_shadow_ctrl i_clkdiv_shadow_ctrl (
        .clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .act_pre(act_pre), .act_fb(act_fb),
        .act_post1(act_post1), .act_post2(act_post2), .act_vco(act_vco)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        addr = 3'(a);
        #1;
        d = int'(rdata);
    endtask

    function automatic int nz(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // raise requests, check pending, poll until clear, push expectation
    task automatic request(string tag, int bits, int s_pre, int s_fb,
                           int s_p1, int s_p2, int s_vco);
        int v;
        wr(0, bits);
        rd(0, v);
        check({tag, " R6 pending after write"}, v & bits, bits);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            rd(0, v);
            if ((v & bits) == 0) break;
        end
        check({tag, " R6 request cleared"}, v & bits, 0);
        if (bits[0]) begin m_pre = nz(s_pre); m_fb = nz(s_fb); end
        if (bits[1]) begin m_p1 = nz(s_p1); m_p2 = nz(s_p2); end
        if (bits[2]) m_vco = nz(s_vco);
        sb_q.push_back('{tag, m_pre, m_fb, m_p1, m_p2, m_vco});
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // monitor: compare active outputs against the scoreboard
    initial begin
        exp_t e;
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            e = sb_q.pop_front();
            check({e.tag, " act_pre"},   int'(act_pre),   e.pre);
            check({e.tag, " act_fb"},    int'(act_fb),    e.fb);
            check({e.tag, " act_post1"}, int'(act_post1), e.p1);
            check({e.tag, " act_post2"}, int'(act_post2), e.p2);
            check({e.tag, " act_vco"},   int'(act_vco),   e.vco);
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 act_pre", int'(act_pre), 1);
        check("R1 act_fb", int'(act_fb), 1);
        check("R1 act_post1", int'(act_post1), 1);
        check("R1 act_post2", int'(act_post2), 1);
        check("R1 act_vco", int'(act_vco), 1);
        rd(0, v); check("R1 ctrl", v, 0);
        for (int a = 1; a <= 5; a++) begin
            rd(a, v); check("R1 R2 staging reset", v, 1);
        end

        // R9 staging alone leaves active untouched
        wr(1, 3); wr(2, 100);
        repeat (8) @(negedge clk);
        check("R9 act_pre before request", int'(act_pre), 1);
        check("R9 act_fb before request", int'(act_fb), 1);
        rd(2, v); check("R2 fb readback", v, 100);

        // R3 prescaler+feedback group
        request("R3", 3'b001, 3, 100, 1, 1, 1);

        // R4 postscaler group
        wr(3, 5); wr(4, 2);
        request("R4", 3'b010, 3, 100, 5, 2, 1);

        // R5 tap divider group
        wr(5, 2);
        request("R5", 3'b100, 3, 100, 5, 2, 2);

        // R7 staging locked while pending
        wr(1, 4);
        wr(0, 1);
        wr(1, 7);
        wr(2, 9);
        rd(1, v); check("R7 pre locked", v, 4);
        rd(2, v); check("R7 fb locked", v, 100);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); rd(0, v);
            if (v == 0) break;
        end
        m_pre = 4;
        sb_q.push_back('{"R7", m_pre, m_fb, m_p1, m_p2, m_vco});
        wait (sb_q.size() == 0);
        @(negedge clk);

        // R10 writing zero bits does nothing
        wr(4, 3);
        wr(0, 0);
        repeat (10) @(negedge clk);
        rd(0, v); check("R10 ctrl stays clear", v, 0);
        check("R10 act_post2 unchanged", int'(act_post2), 2);

        // R8 zero applied as one, R10 concurrent groups
        wr(2, 0); wr(3, 0); wr(5, 0);
        request("R8 R10", 3'b111, 4, 0, 0, 3, 0);
        rd(2, v); check("R8 staging keeps zero", v, 0);

        // widest values
        wr(1, 31); wr(2, 511); wr(3, 7); wr(4, 7); wr(5, 255);
        request("R3 R4 R5 max", 3'b111, 31, 511, 7, 7, 255);

        done = 1;
        finish_run();
    end
endmodule